// File: doc/BRIEF.md
# Sorted Access Wide-Word Coalescer

This block packs a stream of narrow memory requests into accesses of one fixed wide port width. Each request carries a byte offset from a shared base and a size code. The offsets must arrive in ascending order. The first request that is not yet placed opens a window. The window starts at that request's offset and covers the full port width. Later requests join the window for as long as their last byte stays inside it. Holes between requests are tolerated and left unused.

For every accepted request the block emits one output beat. The beat gives the index of the window the request landed in and the byte lane where its data starts inside that window. When a request forces a new window, the beat also reports the start offset of the window that was just closed. When a request carries the end-of-stream flag, the beat also reports the window that is still open, so that no window is lost. Both sides use valid/ready handshakes. A single register stage sits between input and output.

A request that goes backwards in offset is reported as an order error and is not packed. A request with an illegal size code is treated the same way.

Top module: `wide_coalescer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The first request of a stream opens window index 0. Its beat shows lane 0, `out_close_valid` = 0 and `out_err` = 0.
- R3: A request whose last byte (offset + bytes − 1) does not exceed the window limit (window start + port bytes − 1) joins the current window, even when unused bytes lie before it. Its beat keeps the window index and shows lane = offset − window start. Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes.
- R4: A request whose last byte passes the limit closes the current window and opens a new one at its own offset. Its beat shows `out_close_valid` = 1, `out_close_start` = start of the old window, the window index incremented by 1, and lane 0.
- R5: The limit is inclusive. A last byte equal to the limit joins the window. A last byte one past the limit opens a new window.
- R6: With a 16-byte port, sixteen 1-byte requests at consecutive offsets all share window 0, on lanes 0 to 15.
- R7: A request with `in_last` = 1 yields `out_last` = 1 and, if a window is open after it, `out_flush_valid` = 1 with `out_flush_start` = that window's start. The next request starts a fresh stream: window index 0, and no order comparison against the old stream.
- R8: A request whose offset is lower than that of the previous packed request in the same stream yields `out_err` = 1 and `out_close_valid` = 0. It leaves the window, the index and the order reference unchanged. An equal offset is legal.
- R9: Size code 3 yields `out_err` = 1. The request is dropped exactly as in R8.
- R10: `in_ready` = !`out_valid` || `out_ready`. Each accepted request produces exactly one beat, on the cycle after acceptance. While `out_valid` = 1 and `out_ready` = 0, every output field holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_offset | input | OFS_W | Byte offset from the common base |
| in_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = illegal |
| in_last | input | 1 | Final request of the stream |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Beat consumed when high with out_valid |
| out_err | output | 1 | Request dropped (order or size error) |
| out_win_idx | output | IDX_W | Window index of the request |
| out_lane | output | LANE_W | Byte lane inside the window |
| out_close_valid | output | 1 | A window was closed by this request |
| out_close_start | output | OFS_W | Start offset of the closed window |
| out_flush_valid | output | 1 | The open window is flushed at end of stream |
| out_flush_start | output | OFS_W | Start offset of the flushed window |
| out_last | output | 1 | Echo of in_last |

## Verification
The hardest case to reach from the ports is a dropped request that leaves no trace. A wrong order or a bad size must leave the window start, the index and the order reference untouched. The beat of the dropped request shows none of this. So each such request is followed by a legal one whose lane and index can only be right if nothing moved. An order error that carries the end-of-stream flag is also sent; it checks that the earlier window is still flushed. Back-pressure is produced by holding `out_ready` low while a second request waits. This checks that the beat holds and that no request slips in.

// File: rtl/cw_pkg.sv
package cw_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_code_e;

  // Byte count of a size code; illegal code maps to zero.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      SZ_WORD: size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/cw_order_chk.sv
module cw_order_chk #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [OFS_W-1:0] offset,
  input  logic             size_bad,
  input  logic             last,
  output logic             err
);

  logic             ref_vld_q, ref_vld_d;
  logic [OFS_W-1:0] ref_ofs_q, ref_ofs_d;

  assign err = size_bad || (ref_vld_q && (offset < ref_ofs_q));

  always_comb begin
    ref_vld_d = ref_vld_q;
    ref_ofs_d = ref_ofs_q;
    if (fire) begin
      if (last) begin
        ref_vld_d = 1'b0;
      end else if (!err) begin
        ref_vld_d = 1'b1;
        ref_ofs_d = offset;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_vld_q <= 1'b0;
      ref_ofs_q <= '0;
    end else if (fire) begin
      ref_vld_q <= ref_vld_d;
      ref_ofs_q <= ref_ofs_d;
    end
  end

  // R8: a packed, non-final request becomes the order reference
  a_r8_ref_update: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !err && !last) |=> (ref_vld_q && ref_ofs_q == $past(offset)));

endmodule

// File: rtl/cw_window.sv
module cw_window #(
  parameter int OFS_W      = 16,
  parameter int PORT_BYTES = 16,
  parameter int IDX_W      = 8,
  parameter int LANE_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [OFS_W-1:0]  offset,
  input  logic [2:0]        nbytes,
  input  logic              err,
  input  logic              last,
  output logic [IDX_W-1:0]  idx,
  output logic [LANE_W-1:0] lane,
  output logic              close_v,
  output logic [OFS_W-1:0]  close_start,
  output logic              flush_v,
  output logic [OFS_W-1:0]  flush_start
);

  localparam int EW = OFS_W + 1;

  logic             open_q, open_a;
  logic [OFS_W-1:0] start_q, start_a;
  logic [EW-1:0]    limit_q, limit_a;
  logic [IDX_W-1:0] idx_q, idx_a;
  logic [EW-1:0]    last_byte;
  logic             fits;

  assign last_byte = EW'(offset) + EW'(nbytes) - EW'(1);
  assign fits      = open_q && (last_byte <= limit_q);

  // State after this request, and the beat fields it produces
  always_comb begin
    open_a      = open_q;
    start_a     = start_q;
    limit_a     = limit_q;
    idx_a       = idx_q;
    idx         = '0;
    lane        = '0;
    close_v     = 1'b0;
    close_start = '0;
    if (!err) begin
      if (fits) begin
        idx  = idx_q;
        lane = LANE_W'(offset - start_q);
      end else begin
        close_v     = open_q;
        close_start = start_q;
        open_a      = 1'b1;
        start_a     = offset;
        limit_a     = EW'(offset) + EW'(PORT_BYTES - 1);
        idx_a       = open_q ? idx_q + IDX_W'(1) : idx_q;
        idx         = idx_a;
      end
    end
    flush_v     = last && open_a;
    flush_start = start_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      start_q <= '0;
      limit_q <= '0;
      idx_q   <= '0;
    end else if (fire) begin
      open_q  <= last ? 1'b0 : open_a;
      start_q <= start_a;
      limit_q <= limit_a;
      idx_q   <= last ? '0 : idx_a;
    end
  end

  // R5: an absorbed request never reaches past the window end
  a_r5_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !err && fits) |-> (32'(lane) + 32'(nbytes) <= PORT_BYTES));

endmodule

// File: rtl/wide_coalescer.sv
module wide_coalescer #(
  parameter int OFS_W     = 16,
  parameter int PORT_BITS = 128,
  parameter int IDX_W     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [OFS_W-1:0]               in_offset,
  input  logic [1:0]                     in_size,
  input  logic                           in_last,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic                           out_err,
  output logic [IDX_W-1:0]               out_win_idx,
  output logic [$clog2(PORT_BITS/8)-1:0] out_lane,
  output logic                           out_close_valid,
  output logic [OFS_W-1:0]               out_close_start,
  output logic                           out_flush_valid,
  output logic [OFS_W-1:0]               out_flush_start,
  output logic                           out_last
);

  import cw_pkg::*;

  localparam int PORT_BYTES = PORT_BITS / 8;
  localparam int LANE_W     = $clog2(PORT_BYTES);

  logic              fire;
  logic              err;
  logic [2:0]        nbytes;
  logic              size_bad;
  logic [IDX_W-1:0]  w_idx;
  logic [LANE_W-1:0] w_lane;
  logic              w_cv, w_fv;
  logic [OFS_W-1:0]  w_cs, w_fs;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign nbytes   = size_bytes(in_size);
  assign size_bad = (in_size == SZ_BAD);

  cw_order_chk #(.OFS_W(OFS_W)) u_order (
    .clk(clk), .rst_n(rst_n), .fire(fire), .offset(in_offset),
    .size_bad(size_bad), .last(in_last), .err(err)
  );

  cw_window #(
    .OFS_W(OFS_W), .PORT_BYTES(PORT_BYTES), .IDX_W(IDX_W), .LANE_W(LANE_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .fire(fire), .offset(in_offset),
    .nbytes(nbytes), .err(err), .last(in_last),
    .idx(w_idx), .lane(w_lane), .close_v(w_cv), .close_start(w_cs),
    .flush_v(w_fv), .flush_start(w_fs)
  );

  // Output stage: valid next-state and payload load enable
  logic vld_d;
  always_comb begin
    vld_d = out_valid;
    if (fire)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_err         <= 1'b0;
      out_win_idx     <= '0;
      out_lane        <= '0;
      out_close_valid <= 1'b0;
      out_close_start <= '0;
      out_flush_valid <= 1'b0;
      out_flush_start <= '0;
      out_last        <= 1'b0;
    end else if (fire) begin
      out_err         <= err;
      out_win_idx     <= w_idx;
      out_lane        <= w_lane;
      out_close_valid <= w_cv;
      out_close_start <= w_cs;
      out_flush_valid <= w_fv;
      out_flush_start <= w_fs;
      out_last        <= in_last;
    end
  end

  // R10: a stalled beat holds every field
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_err, out_win_idx,
      out_lane, out_close_valid, out_close_start, out_flush_valid,
      out_flush_start, out_last})));

  // R7: a flush is only reported on the final beat
  a_r7_flush_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flush_valid) |-> out_last);

  // R8: a dropped request never closes a window
  a_r8_err_no_close: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> !out_close_valid);

  // R4: a request that opens a window sits on lane 0
  a_r4_close_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_close_valid) |-> (out_lane == '0 && !out_err));

endmodule

// File: tb/wide_coalescer_test.sv
`timescale 1ns/1ps
module wide_coalescer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_last;
  logic [15:0] in_offset;
  logic [1:0]  in_size;
  logic        out_valid, out_ready, out_err, out_close_valid, out_flush_valid, out_last;
  logic [7:0]  out_win_idx;
  logic [3:0]  out_lane;
  logic [15:0] out_close_start, out_flush_start;

  int total = 0;
  int failed = 0;

  always #2 clk = ~clk;

  wide_coalescer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_offset(in_offset), .in_size(in_size), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err),
    .out_win_idx(out_win_idx), .out_lane(out_lane),
    .out_close_valid(out_close_valid), .out_close_start(out_close_start),
    .out_flush_valid(out_flush_valid), .out_flush_start(out_flush_start),
    .out_last(out_last)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one request, then check its beat one cycle later.
  // ex_err = 1 skips the idx/lane checks.
  task automatic send(input string tag, input int ofs, input int sz, input bit lst,
                      input bit ex_err, input int ex_idx, input int ex_lane,
                      input bit ex_cv, input int ex_cs, input bit ex_fv, input int ex_fs);
    @(negedge clk);
    in_valid  = 1'b1;
    in_offset = 16'(ofs);
    in_size   = 2'(sz);
    in_last   = lst;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, int'(out_valid), 1);
    check({tag, " err"}, int'(out_err), int'(ex_err));
    if (!ex_err) begin
      check({tag, " idx"}, int'(out_win_idx), ex_idx);
      check({tag, " lane"}, int'(out_lane), ex_lane);
    end
    check({tag, " close_v"}, int'(out_close_valid), int'(ex_cv));
    if (ex_cv) check({tag, " close_start"}, int'(out_close_start), ex_cs);
    check({tag, " last"}, int'(out_last), int'(lst));
    check({tag, " flush_v"}, int'(out_flush_valid), int'(ex_fv));
    if (ex_fv) check({tag, " flush_start"}, int'(out_flush_start), ex_fs);
  endtask

  task automatic t_reset();
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_basic();
    send("R2 first", 0, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R3 ofs4", 4, 2, 0, 0, 0, 4, 0, 0, 0, 0);
    send("R3 hole ofs12", 12, 2, 0, 0, 0, 12, 0, 0, 0, 0);
    send("R4 ofs20", 20, 2, 1, 0, 1, 0, 1, 0, 1, 20);
  endtask

  task automatic t_boundary();
    send("R5 open", 0, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R5 at limit", 14, 1, 0, 0, 0, 14, 0, 0, 0, 0);
    send("R5 past limit", 15, 1, 0, 0, 1, 0, 1, 0, 0, 0);
    send("R5 lane15", 30, 0, 1, 0, 1, 15, 0, 0, 1, 15);
    send("R7 new stream", 5, 2, 1, 0, 0, 0, 0, 0, 1, 5);
  endtask

  task automatic t_bytes();
    for (int i = 0; i < 16; i++)
      send("R6 byte", 100 + i, 0, i == 15, 0, 0, i, 0, 0, i == 15, 100);
  endtask

  task automatic t_order();
    send("R8 open", 40, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R8 ofs44", 44, 1, 0, 0, 0, 4, 0, 0, 0, 0);
    send("R8 backward", 42, 2, 0, 1, 0, 0, 0, 0, 0, 0);
    send("R8 after drop", 46, 1, 0, 0, 0, 6, 0, 0, 0, 0);
    send("R8 equal ofs", 46, 0, 0, 0, 0, 6, 0, 0, 0, 0);
    send("R9 bad size", 50, 3, 0, 1, 0, 0, 0, 0, 0, 0);
    send("R9 after drop", 52, 2, 1, 0, 0, 12, 0, 0, 1, 40);
    send("R8 open2", 60, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    send("R8 err last", 10, 2, 1, 1, 0, 0, 0, 0, 1, 60);
    send("R7 restart", 3, 0, 1, 0, 0, 0, 0, 0, 1, 3);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_offset = 16'd200; in_size = 2'd2; in_last = 1'b0;
    @(negedge clk);
    in_offset = 16'd204; in_last = 1'b1;
    check("R10 stalled valid", int'(out_valid), 1);
    check("R10 in_ready low", int'(in_ready), 0);
    @(negedge clk);
    check("R10 hold lane", int'(out_lane), 0);
    check("R10 hold last", int'(out_last), 0);
    check("R10 hold idx", int'(out_win_idx), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next valid", int'(out_valid), 1);
    check("R10 next lane", int'(out_lane), 4);
    check("R10 next flush", int'(out_flush_start), 200);
    @(negedge clk);
    check("R10 drained", int'(out_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_offset = '0; in_size = '0; in_last = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_boundary();
    t_bytes();
    t_order();
    t_backpressure();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #400000;
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule